// File: doc/BRIEF.md
# Segment Access Guard

The guard inspects one memory access against the attributes of the segment it goes through, before paging sees it. It looks at the access address and byte count, the write and execute flags, and the segment's permissions, base and limit. It then decides whether the access raises a general-protection fault. Accesses that pass are handed on. The hand-off carries a flag that says whether the address still needs a TLB lookup or is already the physical address.

Accesses enter on a valid/ready stream and leave on a valid/ready stream through a single output register. An access is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output fields hold their values and no new access is taken. The mode and segment inputs are plain control pins, sampled together with the access. Descriptor loading and base addition happen elsewhere: `in_addr` is the offset within the segment.

Top module: `seg_guard`

## Requirements
- R1: Checks run only when `mode_prot` is 1 and not both `mode_long_active` and `mode_cs_long` are 1. Otherwise `out_fault` is 0 whatever the permissions and bounds.
- R2: With checks running, an access with `in_write`=1 to a segment with `seg_writable`=0 faults.
- R3: With checks running, a data read (`in_write`=0 and `in_exec`=0) from a segment with `seg_readable`=0 faults. An execute access does not need `seg_readable`.
- R4: Let end = `in_addr` + `in_size`. For an expand-up segment (`seg_expand_down`=0) whose limit is at least its base, the access faults when limit < end.
- R5: For an expand-up segment whose limit is below its base, the access faults only when limit < end and `in_addr` < base.
- R6: For an expand-down segment (`seg_expand_down`=1) whose limit is at least its base, the access faults when `in_addr` <= limit and end >= base.
- R7: For an expand-down segment whose limit is below its base, the access faults when `in_addr` <= limit or end >= base.
- R8: end is formed one bit wider than the address, so an access that runs past the top of the address space does not wrap. With limit = all ones, base 0 and `in_addr` = all ones minus 1, a 4-byte access faults and a 1-byte access does not.
- R9: `out_addr` always equals the accepted `in_addr`. `out_to_tlb` is 1 only when `mode_prot`=1, `mode_paging`=1 and the access did not fault. Otherwise the address is physical and `out_to_tlb` is 0.
- R10: The result appears with `out_valid`=1 on the clock edge after acceptance. After reset, `out_valid` is 0 and `in_ready` is 1.
- R11: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `out_fault`, `out_to_tlb` and `out_addr` hold their values. Raising `out_ready` drains the held result and accepts a waiting access on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Access offered |
| in_ready | output | 1 | Guard can take an access this cycle |
| in_addr | input | ADDR_W | Offset of the access within the segment |
| in_size | input | SIZE_W | Access length in bytes |
| in_write | input | 1 | Access is a store |
| in_exec | input | 1 | Access is an instruction fetch |
| seg_readable | input | 1 | Segment allows data reads |
| seg_writable | input | 1 | Segment allows writes |
| seg_expand_down | input | 1 | Segment grows downward |
| seg_base | input | ADDR_W | Segment base |
| seg_limit | input | ADDR_W | Segment limit |
| mode_prot | input | 1 | Protected mode on |
| mode_paging | input | 1 | Paging on |
| mode_long_active | input | 1 | Long mode active |
| mode_cs_long | input | 1 | Code segment is 64-bit |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_fault | output | 1 | General-protection fault |
| out_to_tlb | output | 1 | Address must go through TLB lookup |
| out_addr | output | ADDR_W | Forwarded address |

## Verification
The assertions check the following on every cycle:
- the mode bypass: no fault outside protected mode or in 64-bit code;
- the write-permission fault;
- that a fault never reaches the TLB path;
- that paging off forces the physical path;
- that a stalled result stays put.

Only the bench's scenarios can show the four bound cases, which need chosen base, limit and address values on each side of the edges. The same holds for the carry past the top of the address space, the exemption of execute from readability, and the exact one-cycle latency.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

  typedef struct packed {
    logic rd_ok;
    logic wr_ok;
    logic grows_down;
  } seg_perm_t;

  typedef struct packed {
    logic prot_on;
    logic page_on;
    logic long_act;
    logic cs_wide;
  } cpu_mode_t;

endpackage

// File: rtl/seg_mode_gate.sv
module seg_mode_gate
  import seg_chk_pkg::*;
(
  input  cpu_mode_t mode,
  output logic      check_en,
  output logic      page_path
);
  // 64-bit code segments under long mode skip segmentation checks.
  logic wide_code;
  assign wide_code = mode.long_act & mode.cs_wide;
  assign check_en  = mode.prot_on & ~wide_code;
  // Paging is meaningful only once protection is on.
  assign page_path = mode.prot_on & mode.page_on;
endmodule

// File: rtl/seg_rights_chk.sv
module seg_rights_chk
  import seg_chk_pkg::*;
(
  input  seg_perm_t perm,
  input  logic      is_store,
  input  logic      is_fetch,
  output logic      bad_rights
);
  logic store_bad, load_bad;
  assign store_bad  = is_store & ~perm.wr_ok;
  assign load_bad   = ~is_store & ~is_fetch & ~perm.rd_ok;
  assign bad_rights = store_bad | load_bad;
endmodule

// File: rtl/seg_bound_chk.sv
module seg_bound_chk #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] nbytes,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  input  logic              grows_down,
  output logic              bad_bound
);
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] addr_x, end_x, base_x, lim_x;
  logic lim_ge_base, past_limit, under_base, within_limit, hits_base;

  assign addr_x = {1'b0, addr};
  assign base_x = {1'b0, base};
  assign lim_x  = {1'b0, limit};
  // Extra bit keeps the carry, so a run past the top is never lost.
  assign end_x  = addr_x + EXT_W'(nbytes);

  assign lim_ge_base  = limit >= base;
  assign past_limit   = lim_x < end_x;
  assign under_base   = addr < base;
  assign within_limit = addr <= limit;
  assign hits_base    = end_x >= base_x;

  always_comb begin
    unique case ({grows_down, lim_ge_base})
      2'b01:   bad_bound = past_limit;
      2'b00:   bad_bound = past_limit & under_base;
      2'b11:   bad_bound = within_limit & hits_base;
      default: bad_bound = within_limit | hits_base;
    endcase
  end
endmodule

// File: rtl/seg_guard.sv
module seg_guard
  import seg_chk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [SIZE_W-1:0] in_size,
  input  logic              in_write,
  input  logic              in_exec,
  input  logic              seg_readable,
  input  logic              seg_writable,
  input  logic              seg_expand_down,
  input  logic [ADDR_W-1:0] seg_base,
  input  logic [ADDR_W-1:0] seg_limit,
  input  logic              mode_prot,
  input  logic              mode_paging,
  input  logic              mode_long_active,
  input  logic              mode_cs_long,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_fault,
  output logic              out_to_tlb,
  output logic [ADDR_W-1:0] out_addr
);
  seg_perm_t perm;
  cpu_mode_t mode;
  logic check_en, page_path, bad_rights, bad_bound, fault_d, take;

  assign perm = '{rd_ok: seg_readable, wr_ok: seg_writable, grows_down: seg_expand_down};
  assign mode = '{prot_on: mode_prot, page_on: mode_paging,
                  long_act: mode_long_active, cs_wide: mode_cs_long};

  seg_mode_gate u_mode (
    .mode      (mode),
    .check_en  (check_en),
    .page_path (page_path)
  );

  seg_rights_chk u_rights (
    .perm       (perm),
    .is_store   (in_write),
    .is_fetch   (in_exec),
    .bad_rights (bad_rights)
  );

  seg_bound_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_bound (
    .addr       (in_addr),
    .nbytes     (in_size),
    .base       (seg_base),
    .limit      (seg_limit),
    .grows_down (seg_expand_down),
    .bad_bound  (bad_bound)
  );

  assign fault_d  = check_en & (bad_rights | bad_bound);
  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_fault  <= 1'b0;
      out_to_tlb <= 1'b0;
      out_addr   <= '0;
    end else begin
      if (take) begin
        out_valid  <= 1'b1;
        out_fault  <= fault_d;
        out_to_tlb <= page_path & ~fault_d;
        out_addr   <= in_addr;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end

  AST_BYPASS_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    take && (!mode_prot || (mode_long_active && mode_cs_long)) |=> !out_fault); // R1

  AST_STORE_RO_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    take && mode_prot && !(mode_long_active && mode_cs_long) && in_write && !seg_writable
    |=> out_fault); // R2

  AST_FAULT_SKIPS_TLB: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fault |-> !out_to_tlb); // R9

  AST_NO_PAGING_PHYS: assert property (@(posedge clk) disable iff (!rst_n)
    take && !mode_paging |=> !out_to_tlb && out_addr == $past(in_addr)); // R9

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_fault) && $stable(out_to_tlb)
    && $stable(out_addr)); // R11

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R11
endmodule

// File: tb/seg_guard_tb.sv
module seg_guard_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [AW-1:0] in_addr = '0;
  logic [SW-1:0] in_size = '0;
  logic in_write = 1'b0, in_exec = 1'b0;
  logic seg_readable = 1'b1, seg_writable = 1'b1, seg_expand_down = 1'b0;
  logic [AW-1:0] seg_base = '0, seg_limit = '1;
  logic mode_prot = 1'b1, mode_paging = 1'b1, mode_long_active = 1'b0, mode_cs_long = 1'b0;
  logic out_valid, out_ready = 1'b1, out_fault, out_to_tlb;
  logic [AW-1:0] out_addr;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_guard #(.ADDR_W(AW), .SIZE_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_size(in_size), .in_write(in_write), .in_exec(in_exec),
    .seg_readable(seg_readable), .seg_writable(seg_writable),
    .seg_expand_down(seg_expand_down), .seg_base(seg_base), .seg_limit(seg_limit),
    .mode_prot(mode_prot), .mode_paging(mode_paging),
    .mode_long_active(mode_long_active), .mode_cs_long(mode_cs_long),
    .out_valid(out_valid), .out_ready(out_ready), .out_fault(out_fault),
    .out_to_tlb(out_to_tlb), .out_addr(out_addr)
  );

  task automatic check(input string req, input string what, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic defaults();
    seg_readable = 1; seg_writable = 1; seg_expand_down = 0;
    seg_base = '0; seg_limit = '1;
    mode_prot = 1; mode_paging = 1; mode_long_active = 0; mode_cs_long = 0;
    in_write = 0; in_exec = 0; in_size = 4;
  endtask

  // Offer one access at a negedge; it is taken at the next posedge and the
  // result is sampled at the following negedge.
  task automatic run(input string req, input logic [AW-1:0] a, input logic [SW-1:0] sz,
                     input logic exp_fault, input logic exp_tlb);
    @(negedge clk);
    in_addr = a; in_size = sz; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    check(req, "out_valid", AW'(out_valid), AW'(1'b1));
    check(req, "out_fault", AW'(out_fault), AW'(exp_fault));
    check(req, "out_to_tlb", AW'(out_to_tlb), AW'(exp_tlb));
    check(req, "out_addr", out_addr, a);
  endtask

  task automatic t_reset();
    check("R10", "reset out_valid", AW'(out_valid), AW'(1'b0));
    check("R10", "reset in_ready", AW'(in_ready), AW'(1'b1));
  endtask

  task automatic t_mode_gate();
    defaults();
    seg_writable = 0; in_write = 1;
    mode_prot = 0;
    run("R1", 32'h10, 4, 1'b0, 1'b0);
    mode_prot = 1; mode_long_active = 1; mode_cs_long = 1;
    run("R1", 32'h10, 4, 1'b0, 1'b1);
    mode_cs_long = 0;
    run("R1", 32'h10, 4, 1'b1, 1'b0);
  endtask

  task automatic t_write_perm();
    defaults();
    in_write = 1; seg_writable = 0;
    run("R2", 32'h100, 4, 1'b1, 1'b0);
    seg_writable = 1;
    run("R2", 32'h100, 4, 1'b0, 1'b1);
  endtask

  task automatic t_read_perm();
    defaults();
    seg_readable = 0;
    run("R3", 32'h200, 4, 1'b1, 1'b0);
    in_exec = 1;
    run("R3", 32'h200, 4, 1'b0, 1'b1);
  endtask

  task automatic t_up_normal();
    defaults();
    seg_base = 32'h1000; seg_limit = 32'h1FFF;
    run("R4", 32'h1FFC, 4, 1'b1, 1'b0);
    run("R4", 32'h1FFB, 4, 1'b0, 1'b1);
  endtask

  task automatic t_up_wrapped();
    defaults();
    seg_base = 32'h8000; seg_limit = 32'h0FFF;
    run("R5", 32'h9000, 4, 1'b0, 1'b1);
    run("R5", 32'h2000, 4, 1'b1, 1'b0);
    run("R5", 32'h0100, 4, 1'b0, 1'b1);
  endtask

  task automatic t_down_normal();
    defaults();
    seg_expand_down = 1; seg_base = 32'h1000; seg_limit = 32'h3000;
    run("R6", 32'h2000, 4, 1'b1, 1'b0);
    run("R6", 32'h4000, 4, 1'b0, 1'b1);
    run("R6", 32'h0100, 4, 1'b0, 1'b1);
  endtask

  task automatic t_down_wrapped();
    defaults();
    seg_expand_down = 1; seg_base = 32'h8000; seg_limit = 32'h1000;
    run("R7", 32'h0800, 4, 1'b1, 1'b0);
    run("R7", 32'h9000, 4, 1'b1, 1'b0);
    run("R7", 32'h4000, 4, 1'b0, 1'b1);
  endtask

  task automatic t_carry();
    defaults();
    run("R8", 32'hFFFF_FFFE, 4, 1'b1, 1'b0);
    run("R8", 32'hFFFF_FFFE, 1, 1'b0, 1'b1);
  endtask

  task automatic t_phys();
    defaults();
    mode_paging = 0;
    run("R9", 32'h1234_5678, 2, 1'b0, 1'b0);
    mode_prot = 0; mode_paging = 1;
    run("R9", 32'h0000_ABCD, 2, 1'b0, 1'b0);
  endtask

  task automatic t_latency();
    defaults();
    @(negedge clk);
    in_addr = 32'h40; in_size = 4; in_valid = 1;
    check("R10", "empty before take", AW'(out_valid), AW'(1'b0));
    @(negedge clk);
    in_valid = 0;
    check("R10", "valid one edge later", AW'(out_valid), AW'(1'b1));
    @(negedge clk);
    check("R10", "drained", AW'(out_valid), AW'(1'b0));
  endtask

  task automatic t_backpressure();
    defaults();
    seg_writable = 0; in_write = 1;
    out_ready = 0;
    @(negedge clk);
    in_addr = 32'hA0; in_valid = 1;
    @(negedge clk);
    // second access waits: writable, so it should not fault
    in_addr = 32'hB0; seg_writable = 1;
    for (int i = 0; i < 3; i++) begin
      check("R11", "in_ready low", AW'(in_ready), AW'(1'b0));
      check("R11", "held fault", AW'(out_fault), AW'(1'b1));
      check("R11", "held addr", out_addr, 32'hA0);
      @(negedge clk);
    end
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check("R11", "next valid", AW'(out_valid), AW'(1'b1));
    check("R11", "next addr", out_addr, 32'hB0);
    check("R11", "next fault", AW'(out_fault), AW'(1'b0));
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_mode_gate();
        t_write_perm();
        t_read_perm();
        t_up_normal();
        t_up_wrapped();
        t_down_normal();
        t_down_wrapped();
        t_carry();
        t_phys();
        t_latency();
        t_backpressure();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule